// File: doc/BRIEF.md
# Programmable Memory Chip-Select Decoder

This block turns the upper bits of a 20-bit physical address into two active-low chip selects, one for a ROM region and one for a RAM window. The regions are not fixed. Three byte-wide boundary registers set them at run time in 4 KB pages: one ROM ceiling, plus a RAM lower bound and a RAM upper bound. A host programs the registers through a small 8-bit I/O register port.

A fourth register is the control register. It holds a bit that switches the ROM select off. It also holds a two-bit code that picks which of three signal groups owns a set of shared pins. Its last bit orders two interrupt sources that share one request line. The block only produces the select outputs for the pin mux and the priority order. The peripherals behind them are outside the block.

Chip selects are only asserted during memory cycles, which are flagged by the `mreq` strobe. They are registered, so each output reflects the address and strobe seen at the previous rising clock edge.

Top module: `memcs_decoder`

## Requirements
- R1: After synchronous reset, the three boundary registers read 0xFF, the control register reads 0x00, and both chip selects are high.
- R2: The register offsets on `io_addr` are 0xE6 for the RAM upper bound, 0xE7 for the RAM lower bound, 0xE8 for the ROM ceiling and 0xEF for control. While `io_rd` is high, `io_rdata` carries the addressed register in the same cycle. An unmapped offset, or `io_rd` low, gives 0x00.
- R3: A write with `io_wr` high is stored at that rising clock edge, and a later read returns the written byte.
- R4: `rom_cs_n` goes low one cycle after a memory cycle whose page is below the ROM ceiling, while the ROM-disable bit is 0. The page is `addr[19:12]`.
- R5: While control bit 3 (ROM disable) is 1, `rom_cs_n` stays high for every address.
- R6: `ram_cs_n` goes low one cycle after a memory cycle whose page lies between the lower and upper bounds, both included, when the ROM select is not taken.
- R7: When an address qualifies for both regions and ROM is enabled, only `rom_cs_n` goes low.
- R8: With `mreq` low, both chip selects stay high whatever the address.
- R9: Control bits [2:1] drive the one-hot `pin_grp` output. Codes 00 and 01 give 3'b001, code 10 gives 3'b010, and code 11 gives 3'b100.
- R10: `prio_swap` follows control bit 0. A value of 0 means source A is ahead of source B in the shared interrupt chain, and 1 means B is ahead of A.
- R11: The control register keeps bits [3:0] only, and bits [7:4] read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 20 | Physical memory address |
| mreq | input | 1 | Memory-cycle strobe, active high |
| io_addr | input | 8 | Low byte of the I/O register address |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data, combinational |
| rom_cs_n | output | 1 | ROM chip select, active low, registered |
| ram_cs_n | output | 1 | RAM chip select, active low, registered |
| pin_grp | output | 3 | One-hot owner of the shared pins |
| prio_swap | output | 1 | Interrupt order: 1 puts source B first |

## Verification
The hardest case to reach from the ports is an address that falls in both regions. It only arises after both the ROM ceiling and the RAM window have been reprogrammed so that they overlap. The stimulus first sets up disjoint regions and walks a vector table across every boundary edge. It then raises the ROM ceiling into the RAM window to show ROM winning. Finally it sets the disable bit to show RAM taking the same page back. The reset map is a second corner: with all bounds at 0xFF, only the top page selects RAM, and it is probed directly after reset.

// File: rtl/memcs_pkg.sv
package memcs_pkg;
  localparam int unsigned GRP_N = 3;

  function automatic logic [GRP_N-1:0] grp_decode(input logic [1:0] code);
    logic [GRP_N-1:0] oh;
    unique case (code)
      2'b10:   oh = 3'b010;
      2'b11:   oh = 3'b100;
      default: oh = 3'b001;
    endcase
    return oh;
  endfunction
endpackage

// File: rtl/memcs_regfile.sv
module memcs_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IO_AW = 8,
  parameter int unsigned CTRL_W = 4,
  parameter logic [7:0] BND_BASE = 8'hE6,
  parameter logic [7:0] CTRL_OFF = 8'hEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] bnd_up,
  output logic [DATA_W-1:0] bnd_lo,
  output logic [DATA_W-1:0] bnd_rom,
  output logic [CTRL_W-1:0] ctrl
);
  localparam int unsigned NBND = 3;

  logic [DATA_W-1:0] bnd [NBND];
  logic [CTRL_W-1:0] ctrl_q;

  for (genvar g = 0; g < NBND; g++) begin : g_bnd
    localparam logic [IO_AW-1:0] OFF = IO_AW'(BND_BASE + g);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '1;
      else if (io_wr && io_addr == OFF) q <= io_wdata;
    end
    assign bnd[g] = q;

    p_write_r3: assert property (@(posedge clk) disable iff (rst)
      (io_wr && io_addr == OFF) |=> (q == $past(io_wdata)));
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (io_wr && io_addr == IO_AW'(CTRL_OFF)) ctrl_q <= io_wdata[CTRL_W-1:0];
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      for (int i = 0; i < NBND; i++)
        if (io_addr == IO_AW'(BND_BASE + i)) io_rdata = bnd[i];
      if (io_addr == IO_AW'(CTRL_OFF)) io_rdata = DATA_W'(ctrl_q);
    end
  end

  assign bnd_up  = bnd[0];
  assign bnd_lo  = bnd[1];
  assign bnd_rom = bnd[2];
  assign ctrl    = ctrl_q;

  p_rd_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !io_rd |-> (io_rdata == '0));
  p_ctrl_hi_r11: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == IO_AW'(CTRL_OFF)) |-> (io_rdata[DATA_W-1:CTRL_W] == '0));
endmodule

// File: rtl/memcs_cmp.sv
module memcs_cmp #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq,
  input  logic [PAGE_W-1:0] bnd_up,
  input  logic [PAGE_W-1:0] bnd_lo,
  input  logic [PAGE_W-1:0] bnd_rom,
  input  logic              rom_dis,
  output logic              rom_cs_n,
  output logic              ram_cs_n
);
  localparam int unsigned PAGE_LSB = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] page;
  logic rom_hit, ram_hit;

  assign page    = addr[ADDR_W-1:PAGE_LSB];
  assign rom_hit = mreq && !rom_dis && (page < bnd_rom);
  assign ram_hit = mreq && !rom_hit && (page >= bnd_lo) && (page <= bnd_up);

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs_n <= 1'b1;
      ram_cs_n <= 1'b1;
    end else begin
      rom_cs_n <= !rom_hit;
      ram_cs_n <= !ram_hit;
    end
  end

  p_rom_dis_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rom_dis) |-> rom_cs_n);
  p_no_mreq_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(mreq) |-> (rom_cs_n && ram_cs_n));
  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(rom_cs_n == 1'b0 && ram_cs_n == 1'b0));
endmodule

// File: rtl/memcs_pinmux.sv
module memcs_pinmux
  import memcs_pkg::*;
#(
  parameter int unsigned CTRL_W = 4
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic [GRP_N-1:0]  pin_grp,
  output logic              prio_swap
);
  assign pin_grp   = grp_decode(ctrl[2:1]);
  assign prio_swap = ctrl[0];

  always_comb begin
    p_grp_onehot_r9: assert ($countones(pin_grp) == 1);
  end
endmodule

// File: rtl/memcs_decoder.sv
module memcs_decoder
  import memcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IO_AW = 8,
  parameter logic [7:0] BND_BASE = 8'hE6,
  parameter logic [7:0] CTRL_OFF = 8'hEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic [GRP_N-1:0]  pin_grp,
  output logic              prio_swap
);
  localparam int unsigned CTRL_W = 4;
  localparam int unsigned ROM_DIS_BIT = 3;

  logic [DATA_W-1:0] bnd_up, bnd_lo, bnd_rom;
  logic [CTRL_W-1:0] ctrl;

  memcs_regfile #(
    .DATA_W(DATA_W), .IO_AW(IO_AW), .CTRL_W(CTRL_W),
    .BND_BASE(BND_BASE), .CTRL_OFF(CTRL_OFF)
  ) u_regs (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .bnd_up(bnd_up), .bnd_lo(bnd_lo), .bnd_rom(bnd_rom), .ctrl(ctrl)
  );

  memcs_cmp #(.ADDR_W(ADDR_W), .PAGE_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .addr(addr), .mreq(mreq),
    .bnd_up(bnd_up), .bnd_lo(bnd_lo), .bnd_rom(bnd_rom),
    .rom_dis(ctrl[ROM_DIS_BIT]), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n)
  );

  memcs_pinmux #(.CTRL_W(CTRL_W)) u_mux (
    .ctrl(ctrl), .pin_grp(pin_grp), .prio_swap(prio_swap)
  );

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (rom_cs_n && ram_cs_n));
  p_prio_r10: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == IO_AW'(CTRL_OFF)) |=> (prio_swap == $past(io_wdata[0])));
endmodule

// File: tb/sim_memcs_decoder.sv
module sim_memcs_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [19:0] addr = '0;
  logic mreq = 1'b0;
  logic [7:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic rom_cs_n, ram_cs_n, prio_swap;
  logic [2:0] pin_grp;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  memcs_decoder u0 (.*);

  // {mreq, addr[19:0], exp rom_cs_n, exp ram_cs_n}; window 0x40..0x7F, ROM below 0x10
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 20'h00000, 2'b01}, {1'b1, 20'h0FFFF, 2'b01},
    {1'b1, 20'h10000, 2'b11}, {1'b1, 20'h3FFFF, 2'b11},
    {1'b1, 20'h40000, 2'b10}, {1'b1, 20'h7FFFF, 2'b10},
    {1'b1, 20'h80000, 2'b11}, {1'b1, 20'hFFFFF, 2'b11},
    {1'b0, 20'h00000, 2'b11}, {1'b1, 20'h55123, 2'b10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 chk(req, io_rdata, exp);
    io_rd = 1'b0;
  endtask

  task automatic cyc(input string req, input logic m, input logic [19:0] a, input logic [1:0] exp);
    @(negedge clk);
    mreq = m; addr = a;
    @(negedge clk);
    chk(req, {rom_cs_n, ram_cs_n}, exp);
    mreq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 cs", {rom_cs_n, ram_cs_n}, 2'b11);
    rd("R1 up", 8'hE6, 8'hFF);
    rd("R1 lo", 8'hE7, 8'hFF);
    rd("R1 rom", 8'hE8, 8'hFF);
    rd("R1 ctrl", 8'hEF, 8'h00);
    chk("R9 reset grp", pin_grp, 3'b001);
    // reset map: only top page is RAM
    cyc("R6 reset top page", 1'b1, 20'hFF000, 2'b10);
    cyc("R4 reset low page", 1'b1, 20'h00000, 2'b01);
    // program regions (R2 offsets, R3 writes)
    wr(8'hE6, 8'h7F);
    wr(8'hE7, 8'h40);
    wr(8'hE8, 8'h10);
    rd("R3 up", 8'hE6, 8'h7F);
    rd("R3 lo", 8'hE7, 8'h40);
    rd("R3 rom", 8'hE8, 8'h10);
    rd("R2 unmapped", 8'hE9, 8'h00);
    @(negedge clk); io_addr = 8'hE6; io_rd = 1'b0;
    #1 chk("R2 no read strobe", io_rdata, 8'h00);
    // vector walk (R4 R6 R8)
    for (int i = 0; i < NV; i++)
      cyc("R4/R6/R8 vector", VEC[i][22], VEC[i][21:2], VEC[i][1:0]);
    // overlap: ROM wins (R7)
    wr(8'hE8, 8'h50);
    cyc("R7 overlap", 1'b1, 20'h45000, 2'b01);
    cyc("R6 above rom", 1'b1, 20'h50000, 2'b10);
    // disable ROM (R5)
    wr(8'hEF, 8'h08);
    cyc("R5 low addr", 1'b1, 20'h00000, 2'b11);
    cyc("R5 overlap to ram", 1'b1, 20'h45000, 2'b10);
    // R8 mreq low in window
    cyc("R8 idle", 1'b0, 20'h45000, 2'b11);
    // R9 pin groups and R10 priority
    wr(8'hEF, 8'h02); chk("R9 code01", pin_grp, 3'b001); chk("R10 off", prio_swap, 1'b0);
    wr(8'hEF, 8'h04); chk("R9 code10", pin_grp, 3'b010);
    wr(8'hEF, 8'h06); chk("R9 code11", pin_grp, 3'b100);
    wr(8'hEF, 8'h01); chk("R10 on", prio_swap, 1'b1); chk("R9 code00", pin_grp, 3'b001);
    // R11 width of control
    wr(8'hEF, 8'hFF);
    rd("R11 ctrl", 8'hEF, 8'h0F);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule